// File: doc/BRIEF.md
# Memory Address Conflict Matrix

This block keeps track of the load and store operations held by a group of load/store function units. It is a square matrix with one row and one column per unit. When a unit issues an operation, its row records which operations already in flight it must wait for, meaning those whose address may overlap with its own. When a unit completes, its column is wiped from every row, so the units waiting on it are released in order.

Overlap is judged on a middle slice of the address only: bits 11 down to 4. The low byte-offset bits and every bit above the slice are ignored. Two addresses that differ only outside the slice are therefore reported as a conflict. This occasional false match is accepted in exchange for small comparators.

On top of the ordering, the block serves loads and stores in alternating batches. A batch type register selects which kind of operation may proceed, so no group of grants ever mixes the two. This gives weak memory ordering between operations whose addresses do not overlap.

Top module: `addr_conflict_matrix`

## Requirements
- R1: After reset no unit is pending, every mayGo bit and every conflict bit is 0, and the served batch type is load.
- R2: When a free unit issues, its row gets bit j set exactly for each other unit j that is pending, is not completing in that cycle, and whose stored address bits [11:4] equal those of the new address. The row is visible from the cycle after the issue.
- R3: Address bits [3:0] and bits above 11 take no part in the comparison. Addresses that differ only there are flagged as conflicting.
- R4: When several free units issue in the same cycle, a lower-numbered unit counts as older. The higher unit waits on the lower one if their slices match, and never the reverse.
- R5: When a pending unit completes, its column is cleared in every row and its own row is cleared. This is seen from the next cycle.
- R6: An issue request on a unit that is already pending is ignored, and so is a completion on a unit that is not pending.
- R7: mayGo[i] is 1 only when unit i is pending, its row is all zero, and its type (issueIsStore = 1 for a store, 0 for a load) equals the batch type being served.
- R8: The batch type changes only when no pending operation of the current type has an empty row and at least one of the other type does. The change takes effect one cycle later.
- R9: mayGo never grants a load and a store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | NUM_UNITS | Per-unit issue request |
| issueAddr | input | NUM_UNITS*ADDR_W | Per-unit address, unit i in bits [i*ADDR_W +: ADDR_W] |
| issueIsStore | input | NUM_UNITS | Per-unit type, 1 = store, 0 = load |
| doneValid | input | NUM_UNITS | Per-unit completion |
| mayGo | output | NUM_UNITS | Unit may proceed to memory |
| conflictBits | output | NUM_UNITS*NUM_UNITS | Bit i*NUM_UNITS+j set: unit i waits for unit j |

## Verification
Directed cases come first. A pair of addresses that differ only in the offset and upper bits tells a slice-only comparison apart from a full one. A pair with different slices shows that an unneeded dependency is not made. Two units issuing in the same cycle expose which direction the age tie-break takes. A short sequence of completions shows the column release and the one-cycle lag of the batch switch. After that, random traffic runs with addresses drawn from a few slice values, so conflicts are frequent. It includes stray issues to busy units and completions to idle ones. The matrix, the grants and the no-mix rule are compared every cycle against a model in the bench.

// File: rtl/acm_pkg.sv
package acm_pkg;
  localparam int UNITS = 8;

  typedef struct packed {
    logic [UNITS-1:0] capture;  // accepted issue per unit
    logic [UNITS-1:0] retire;   // accepted completion per unit
  } acmStrobe_t;
endpackage

// File: rtl/acm_datapath.sv
module acm_datapath
  import acm_pkg::*;
#(
  parameter int NUM_UNITS = UNITS,
  parameter int ADDR_W    = 48,
  parameter int SLICE_LO  = 4,
  parameter int SLICE_HI  = 11
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  acmStrobe_t                     strb,
  input  logic [NUM_UNITS*ADDR_W-1:0]    issueAddr,
  input  logic [NUM_UNITS-1:0]           issueIsStore,
  output logic [NUM_UNITS-1:0]           busy,
  output logic [NUM_UNITS-1:0]           storeFlag,
  output logic [NUM_UNITS-1:0]           rowEmpty,
  output logic [NUM_UNITS*NUM_UNITS-1:0] waitFlat
);
  localparam int SW = SLICE_HI - SLICE_LO + 1;

  logic [SW-1:0]        newTag [NUM_UNITS];
  logic [SW-1:0]        tagQ   [NUM_UNITS];
  logic [NUM_UNITS-1:0] waitQ  [NUM_UNITS];
  logic [NUM_UNITS-1:0] rowNew [NUM_UNITS];
  logic                 unusedAddrBits;

  assign unusedAddrBits = ^issueAddr;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : gTag
    assign newTag[i] = issueAddr[i*ADDR_W+SLICE_LO +: SW];
    assign rowEmpty[i] = (waitQ[i] == '0);
    assign waitFlat[i*NUM_UNITS +: NUM_UNITS] = waitQ[i];
  end

  // dependency row for each unit that is issuing now
  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) begin
      rowNew[i] = '0;
      for (int j = 0; j < NUM_UNITS; j++) begin
        if (j != i) begin
          if (busy[j] && !strb.retire[j] && newTag[i] == tagQ[j])
            rowNew[i][j] = 1'b1;
          if (strb.capture[j] && j < i && newTag[i] == newTag[j])
            rowNew[i][j] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= '0;
      storeFlag <= '0;
      for (int i = 0; i < NUM_UNITS; i++) begin
        tagQ[i]  <= '0;
        waitQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_UNITS; i++) begin
        if (strb.capture[i]) begin
          busy[i]      <= 1'b1;
          storeFlag[i] <= issueIsStore[i];
          tagQ[i]      <= newTag[i];
          waitQ[i]     <= rowNew[i];
        end else if (strb.retire[i]) begin
          busy[i]  <= 1'b0;
          waitQ[i] <= '0;
        end else begin
          waitQ[i] <= waitQ[i] & ~strb.retire;
        end
      end
    end
  end
endmodule

// File: rtl/acm_control.sv
module acm_control
  import acm_pkg::*;
#(
  parameter int NUM_UNITS = UNITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_UNITS-1:0] issueValid,
  input  logic [NUM_UNITS-1:0] doneValid,
  input  logic [NUM_UNITS-1:0] busy,
  input  logic [NUM_UNITS-1:0] storeFlag,
  input  logic [NUM_UNITS-1:0] rowEmpty,
  output acmStrobe_t           strb,
  output logic [NUM_UNITS-1:0] mayGo,
  output logic                 batchIsStore
);
  logic [NUM_UNITS-1:0] eligible;
  logic                 anyLoad;
  logic                 anyStore;

  assign strb.capture = issueValid & ~busy;
  assign strb.retire  = doneValid & busy;

  assign eligible = busy & rowEmpty;
  assign anyLoad  = |(eligible & ~storeFlag);
  assign anyStore = |(eligible & storeFlag);
  assign mayGo    = eligible & (batchIsStore ? storeFlag : ~storeFlag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      batchIsStore <= 1'b0;
    end else if (batchIsStore && !anyStore && anyLoad) begin
      batchIsStore <= 1'b0;
    end else if (!batchIsStore && !anyLoad && anyStore) begin
      batchIsStore <= 1'b1;
    end
  end
endmodule

// File: rtl/addr_conflict_matrix.sv
module addr_conflict_matrix
  import acm_pkg::*;
#(
  parameter int NUM_UNITS = UNITS,
  parameter int ADDR_W    = 48,
  parameter int SLICE_LO  = 4,
  parameter int SLICE_HI  = 11
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_UNITS-1:0]           issueValid,
  input  logic [NUM_UNITS*ADDR_W-1:0]    issueAddr,
  input  logic [NUM_UNITS-1:0]           issueIsStore,
  input  logic [NUM_UNITS-1:0]           doneValid,
  output logic [NUM_UNITS-1:0]           mayGo,
  output logic [NUM_UNITS*NUM_UNITS-1:0] conflictBits
);
  acmStrobe_t           strb;
  logic [NUM_UNITS-1:0] busyVec;
  logic [NUM_UNITS-1:0] storeVec;
  logic [NUM_UNITS-1:0] emptyVec;
  logic                 batchIsStore;

  acm_datapath #(
    .NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W),
    .SLICE_LO(SLICE_LO), .SLICE_HI(SLICE_HI)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .issueAddr(issueAddr), .issueIsStore(issueIsStore),
    .busy(busyVec), .storeFlag(storeVec), .rowEmpty(emptyVec),
    .waitFlat(conflictBits)
  );

  acm_control #(.NUM_UNITS(NUM_UNITS)) uControl (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .doneValid(doneValid),
    .busy(busyVec), .storeFlag(storeVec), .rowEmpty(emptyVec),
    .strb(strb), .mayGo(mayGo), .batchIsStore(batchIsStore)
  );
endmodule

// File: rtl/acm_checker.sv
module acm_checker #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic [N-1:0]   issueValid,
  input logic [N-1:0]   doneValid,
  input logic [N-1:0]   mayGo,
  input logic [N*N-1:0] conflictBits,
  input logic [N-1:0]   busy,
  input logic [N-1:0]   storeFlag,
  input logic           batchIsStore
);
  // R9: grants are all loads or all stores
  a_r9_no_mixed_batch: assert property (@(posedge clk) disable iff (!rstN)
    ((mayGo & storeFlag) != '0) |-> ((mayGo & ~storeFlag) == '0));

  // R8: batch type holds while something of it is granted
  a_r8_batch_holds: assert property (@(posedge clk) disable iff (!rstN)
    (mayGo != '0) |=> $stable(batchIsStore));

  for (genvar i = 0; i < N; i++) begin : gUnit
    logic [N-1:0] colBits;
    for (genvar j = 0; j < N; j++) begin : gCol
      assign colBits[j] = conflictBits[j*N+i];
    end

    // R7: a grant needs a pending unit with an empty row
    a_r7_grant_needs_clear_row: assert property (@(posedge clk) disable iff (!rstN)
      mayGo[i] |-> (busy[i] && conflictBits[i*N +: N] == '0));

    // R5: completion wipes the column
    a_r5_column_cleared: assert property (@(posedge clk) disable iff (!rstN)
      (doneValid[i] && busy[i] && !issueValid[i]) |=> (colBits == '0));

    // R6: issuing on a busy unit leaves its type alone
    a_r6_busy_issue_ignored: assert property (@(posedge clk) disable iff (!rstN)
      (busy[i] && issueValid[i] && !doneValid[i]) |=> (busy[i] && storeFlag[i] == $past(storeFlag[i])));
  end
endmodule

bind addr_conflict_matrix acm_checker #(.N(NUM_UNITS)) uChecker (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .doneValid(doneValid),
  .mayGo(mayGo), .conflictBits(conflictBits), .busy(busyVec),
  .storeFlag(storeVec), .batchIsStore(batchIsStore)
);

// File: tb/addr_conflict_matrix_test.sv
module addr_conflict_matrix_test;
  localparam int N = 8;
  localparam int AW = 48;
  localparam int CLK_PERIOD = 10;

  logic            clk = 0;
  logic            rstN = 0;
  logic [N-1:0]    issueValid = '0;
  logic [N*AW-1:0] issueAddr = '0;
  logic [N-1:0]    issueIsStore = '0;
  logic [N-1:0]    doneValid = '0;
  logic [N-1:0]    mayGo;
  logic [N*N-1:0]  conflictBits;

  addr_conflict_matrix uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueAddr(issueAddr),
    .issueIsStore(issueIsStore), .doneValid(doneValid),
    .mayGo(mayGo), .conflictBits(conflictBits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [N-1:0] mBusy, mStore;
  logic [7:0]   mTag [N];
  logic [N-1:0] mRow [N];
  logic         mBatch;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] expGo();
    logic [N-1:0] el;
    for (int i = 0; i < N; i++) el[i] = mBusy[i] && (mRow[i] == '0);
    return el & (mBatch ? mStore : ~mStore);
  endfunction

  function automatic logic [N*N-1:0] expMatrix();
    logic [N*N-1:0] m;
    for (int i = 0; i < N; i++) m[i*N +: N] = mRow[i];
    return m;
  endfunction

  function automatic logic [7:0] sliceOf(input int u);
    return issueAddr[u*AW+4 +: 8];
  endfunction

  function automatic logic [AW-1:0] mkAddr(input logic [7:0] sl);
    logic [AW-1:0] a;
    a = {$urandom, $urandom};
    a[11:4] = sl;
    return a;
  endfunction

  // apply current inputs for one clock and advance the model
  task automatic step();
    logic [N-1:0] cap, ret, el;
    logic [N-1:0] nRow [N];
    logic [N-1:0] nBusy, nStore;
    logic [7:0]   nTag [N];
    logic         nBatch;
    cap = issueValid & ~mBusy;
    ret = doneValid & mBusy;
    for (int i = 0; i < N; i++) el[i] = mBusy[i] && (mRow[i] == '0);
    nBatch = mBatch;
    if (mBatch && !(|(el & mStore)) && (|(el & ~mStore))) nBatch = 0;
    else if (!mBatch && !(|(el & ~mStore)) && (|(el & mStore))) nBatch = 1;
    nBusy = mBusy; nStore = mStore;
    for (int i = 0; i < N; i++) begin
      nTag[i] = mTag[i];
      nRow[i] = mRow[i] & ~ret;
      if (cap[i]) begin
        nBusy[i] = 1; nStore[i] = issueIsStore[i]; nTag[i] = sliceOf(i);
        nRow[i] = '0;
        for (int j = 0; j < N; j++) begin
          if (j != i && mBusy[j] && !ret[j] && mTag[j] == sliceOf(i)) nRow[i][j] = 1;
          if (j < i && cap[j] && sliceOf(j) == sliceOf(i)) nRow[i][j] = 1;
        end
      end else if (ret[i]) begin
        nBusy[i] = 0; nRow[i] = '0;
      end
    end
    @(posedge clk);
    mBusy = nBusy; mStore = nStore; mBatch = nBatch;
    for (int i = 0; i < N; i++) begin mTag[i] = nTag[i]; mRow[i] = nRow[i]; end
    @(negedge clk);
    issueValid = '0; doneValid = '0;
    check("R2 matrix", 64'(conflictBits), 64'(expMatrix()));
    check("R7 mayGo", 64'(mayGo), 64'(expGo()));
    check("R9 no mix", 64'((|(mayGo & mStore)) && (|(mayGo & ~mStore))), 64'(0));
  endtask

  task automatic issue(input int u, input logic st, input logic [AW-1:0] a);
    issueValid[u] = 1; issueIsStore[u] = st; issueAddr[u*AW +: AW] = a;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mBusy = '0; mStore = '0; mBatch = 0;
    for (int i = 0; i < N; i++) begin mTag[i] = '0; mRow[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 mayGo after reset", 64'(mayGo), 64'(0));
    check("R1 matrix after reset", 64'(conflictBits), 64'(0));

    // R3: same slice, different offset and upper bits -> flagged
    issue(0, 0, 48'h0000_0000_0123);
    step();
    issue(1, 1, 48'hABCD_0000_1128);
    issue(2, 0, 48'h0000_0000_0340);
    step();
    check("R3 false match flagged", 64'(conflictBits[1*N+0]), 64'(1));
    check("R2 distinct slice no dependency", 64'(conflictBits[2*N +: N]), 64'(0));
    check("R7 loads granted", 64'(mayGo), 64'(8'b0000_0101));

    // R6: issue on busy unit 0 as a store is ignored
    issue(0, 1, 48'h0000_0000_0340);
    step();
    check("R6 busy issue ignored", 64'(mayGo[0]), 64'(1));
    check("R6 no new row bit", 64'(conflictBits[0 +: N]), 64'(0));
    // R6: completion of idle unit 5 ignored
    doneValid[5] = 1;
    step();
    check("R6 idle done ignored", 64'(mayGo), 64'(8'b0000_0101));

    // R5 / R8
    doneValid[0] = 1;
    step();
    check("R5 column cleared", 64'(conflictBits[1*N +: N]), 64'(0));
    check("R8 store waits for load batch", 64'(mayGo), 64'(8'b0000_0100));
    doneValid[2] = 1;
    step();
    check("R8 switch lags one cycle", 64'(mayGo), 64'(0));
    step();
    check("R8 store batch served", 64'(mayGo), 64'(8'b0000_0010));
    doneValid[1] = 1;
    step();

    // R4: same-cycle issue, lower index older
    issue(4, 1, mkAddr(8'h77));
    issue(5, 1, mkAddr(8'h77));
    step();
    check("R4 higher waits on lower", 64'(conflictBits[5*N+4]), 64'(1));
    check("R4 lower not waiting", 64'(conflictBits[4*N+5]), 64'(0));
    doneValid[4] = 1; step();
    doneValid[5] = 1; step();
    step();

    // random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int u = 0; u < N; u++) begin
        if ($urandom_range(0, 99) < 20) issue(u, 1'($urandom_range(0, 1)),
                                             mkAddr(8'($urandom_range(0, 3) * 8'h11)));
        if (mayGo[u] && $urandom_range(0, 99) < 50) doneValid[u] = 1;
        else if ($urandom_range(0, 99) < 3) doneValid[u] = 1;
      end
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule